// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block lets an external I2C master read and write a bank of sixteen byte-wide registers. It runs on a system clock much faster than SCL. Both bus lines pass through a two-flop synchroniser, and start, stop and SCL edges are found by comparing successive synchronised samples. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

A transfer opens with a device byte. The even value 0xA2 selects writing and the odd value 0xA3 selects reading. In a write, the byte after the device byte loads a 4-bit word pointer, and every later byte becomes a single-cycle write strobe at that pointer. In a read, bytes are sent from the pointer position and the register bank supplies them on `rd_data`. The pointer steps by one after each data byte in either direction and wraps from 0x0F to 0x00. When a read device byte matches, the block pulses `snap_req` so that the bank can freeze its time counters before the first bit leaves.

States: `S_IDLE`, `S_DEV` (device byte), `S_DEV_ACK`, `S_WADDR` (word address), `S_WADDR_ACK`, `S_WDATA`, `S_WDATA_ACK`, `S_RDATA`, `S_RACK` (master answer). Transitions:
- A start goes from any state to `S_DEV`.
- A stop goes from any state to `S_IDLE`.
- `S_DEV` goes to `S_DEV_ACK` on an address match, and to `S_IDLE` otherwise.
- `S_DEV_ACK` goes to `S_RDATA` for a read and to `S_WADDR` for a write.
- `S_WADDR` goes to `S_WADDR_ACK`, then to `S_WDATA`.
- `S_WDATA` goes to `S_WDATA_ACK`, which returns to `S_WDATA`.
- `S_RDATA` goes to `S_RACK`. From `S_RACK`, an acknowledge returns to `S_RDATA` and a not-acknowledge goes to `S_IDLE`.

Top module: `i2c_regbank_slave`

## Requirements
- R1: SDA falling while SCL is high starts address matching from any state. SDA rising while SCL is high returns the block to idle with SDA released.
- R2: The device bytes 0xA2 (write) and 0xA3 (read) are acknowledged by pulling SDA low during the ninth clock. Any other device byte gets no acknowledge, and the bytes after it are ignored until the next start.
- R3: In a write, the low 4 bits of the byte after the device byte load the word pointer, and the byte is acknowledged.
- R4: Each data byte written produces exactly one single-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte (MSB first on the bus). The byte is acknowledged.
- R5: The pointer steps by one after every data byte read or written, and wraps from 0x0F to 0x00. A read that starts without a word address continues from the pointer left by the previous transfer.
- R6: In a read, the slave shifts out `rd_data` at the pointer, MSB first, changing SDA only while SCL is low. It goes on to the next byte while the master acknowledges, and releases SDA after a not-acknowledge.
- R7: `snap_req` pulses for one cycle when the read device byte matches, once per read, before the first data bit. A byte that does not match never raises it.
- R8: A repeated start without a stop is accepted and restarts address matching.
- R9: A stop that arrives in the middle of a data byte produces no write strobe.
- R10: After reset, SDA is released and neither `wr_en` nor `snap_req` is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | High to pull SDA low (open-drain enable) |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 4 | Register index for the write |
| wr_data | output | 8 | Byte to write |
| rd_addr | output | 4 | Register index whose value must appear on rd_data |
| rd_data | input | 8 | Value of the register selected by rd_addr, unused bits zero |
| snap_req | output | 1 | Pulse asking the bank to latch all time counters |

## Verification
The hardest case to reach from the ports is a read burst that crosses the pointer wrap. The pointer must move at the right moment relative to the master's acknowledge clock, so that the byte loaded after an acknowledge comes from the new index, and SDA must be free once the master answers with a high level. The bench drives the bus bit by bit as a master, with SDA modelled as a wired AND of the master and the slave. It writes a burst from 0x0E across the wrap, reads it back in one burst that ends in a not-acknowledge, and then issues a read with no word address to expose where the pointer was left. A stop inside a half-sent byte and a repeated start inside a write are driven the same way.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } rb_state_e;

endpackage

// File: rtl/i2c_rb_sync.sv
// Brings SCL/SDA into the system clock domain and flags edges and bus conditions.
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA moving while SCL stays high is a bus condition, never data
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rb_ptr.sv
// Word pointer: load has priority over step; natural wrap at 2**AW.
module i2c_rb_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7   = 7'h51,
    parameter int         AW          = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_drive_low,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          snap_req
);

    localparam int         CNT_W   = 4;
    localparam logic [7:0] RD_BYTE = {DEV_ADDR7, 1'b1};

    rb_state_e        state;
    rb_state_e        nxt;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [7:0]       rx_byte;
    logic             mack;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             ptr_inc;
    logic             ptr_load;
    logic [AW-1:0]    ptr_ld_val;
    logic [AW-1:0]    ptr;
    logic             byte_end;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rb_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val(ptr_ld_val),
        .step    (ptr_inc),
        .ptr     (ptr)
    );

    assign rx_byte  = {shreg[6:0], sda_s};
    assign byte_end = scl_fall && (cnt == CNT_W'(8));
    assign wr_addr  = ptr;
    assign rd_addr  = ptr;

    // next-state decode
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_DEV;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_DEV:       if (byte_end) nxt = (shreg[7:1] == DEV_ADDR7) ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:   if (scl_fall) nxt = shreg[0] ? S_RDATA : S_WADDR;
                S_WADDR:     if (byte_end) nxt = S_WADDR_ACK;
                S_WADDR_ACK: if (scl_fall) nxt = S_WDATA;
                S_WDATA:     if (byte_end) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_RDATA:     if (byte_end) nxt = S_RACK;
                S_RACK:      if (scl_fall) nxt = mack ? S_RDATA : S_IDLE;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt           <= '0;
            shreg         <= '0;
            txreg         <= '0;
            mack          <= 1'b0;
            sda_drive_low <= 1'b0;
            wr_en         <= 1'b0;
            wr_data       <= '0;
            snap_req      <= 1'b0;
            ptr_inc       <= 1'b0;
            ptr_load      <= 1'b0;
            ptr_ld_val    <= '0;
        end else begin
            wr_en    <= 1'b0;
            snap_req <= 1'b0;
            ptr_inc  <= 1'b0;
            ptr_load <= 1'b0;
            if (start_det || stop_det) begin
                cnt           <= '0;
                sda_drive_low <= 1'b0;
            end else begin
                if (scl_rise) begin
                    unique case (state)
                        S_DEV, S_WADDR, S_WDATA: begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(7)) begin
                                if (state == S_DEV && rx_byte == RD_BYTE) begin
                                    snap_req <= 1'b1;
                                end
                                if (state == S_WADDR) begin
                                    ptr_load   <= 1'b1;
                                    ptr_ld_val <= rx_byte[AW-1:0];
                                end
                                if (state == S_WDATA) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= rx_byte;
                                end
                            end
                        end
                        S_RDATA: cnt  <= cnt + 1'b1;
                        S_RACK:  mack <= ~sda_s;
                        default: ;
                    endcase
                end
                if (scl_fall) begin
                    unique case (state)
                        S_DEV, S_WADDR, S_WDATA: begin
                            if (cnt == CNT_W'(8)) begin
                                cnt           <= '0;
                                sda_drive_low <= (nxt != S_IDLE);
                            end
                        end
                        S_DEV_ACK, S_WADDR_ACK: begin
                            cnt           <= '0;
                            sda_drive_low <= 1'b0;
                            if (nxt == S_RDATA) begin
                                txreg         <= rd_data;
                                sda_drive_low <= ~rd_data[7];
                            end
                        end
                        S_WDATA_ACK: begin
                            cnt           <= '0;
                            sda_drive_low <= 1'b0;
                            ptr_inc       <= 1'b1;
                        end
                        S_RDATA: begin
                            if (cnt == CNT_W'(8)) begin
                                sda_drive_low <= 1'b0;
                                ptr_inc       <= 1'b1;
                            end else begin
                                txreg         <= {txreg[6:0], 1'b0};
                                sda_drive_low <= ~txreg[6];
                            end
                        end
                        S_RACK: begin
                            cnt <= '0;
                            if (mack) begin
                                txreg         <= rd_data;
                                sda_drive_low <= ~rd_data[7];
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk
    import i2c_rb_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input rb_state_e     state,
    input logic          sda_drive_low,
    input logic          wr_en,
    input logic          snap_req,
    input logic          stop_det,
    input logic          ptr_inc,
    input logic          ptr_load,
    input logic [AW-1:0] ptr
);

    // R4: write strobe lasts one cycle and only inside a data byte
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    a_r4_wr_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_WDATA));

    // R7: snapshot request is a single pulse raised during the device byte
    a_r7_snap_single: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> !snap_req);
    a_r7_snap_in_dev: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |-> (state == S_DEV));

    // R1: a stop leaves the block idle with SDA released
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_drive_low && state == S_IDLE));

    // R5: a step request moves the pointer by exactly one, wrapping
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load) |=> (ptr == $past(ptr) + 1'b1));

    // R10: an idle block never holds SDA low
    a_r10_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_drive_low);

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .sda_drive_low(sda_drive_low),
    .wr_en        (wr_en),
    .snap_req     (snap_req),
    .stop_det     (stop_det),
    .ptr_inc      (ptr_inc),
    .ptr_load     (ptr_load),
    .ptr          (ptr)
);

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 10;
    localparam logic [7:0] WR_B       = 8'hA2;
    localparam logic [7:0] RD_B       = 8'hA3;
    localparam int         NVEC       = 6;
    // {word address, data}
    localparam logic [11:0] VEC [NVEC] = '{12'h3A5, 12'h001, 12'hFFF,
                                           12'h700, 12'hA3C, 12'h496};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_drive_low;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       snap_req;

    logic [7:0] bank [16];
    logic [7:0] exp_mem [16];
    int         wr_cnt;
    int         snap_cnt;
    logic [3:0] last_wr_addr;
    int         errors = 0;
    int         checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_drive_low;
    assign rd_data  = bank[rd_addr];

    i2c_regbank_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_drive_low(sda_drive_low),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .snap_req     (snap_req)
    );

    // register bank model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= 8'(i * 17 + 3);
            wr_cnt       <= 0;
            snap_cnt     <= 0;
            last_wr_addr <= '0;
        end else begin
            if (wr_en) begin
                bank[wr_addr] <= wr_data;
                wr_cnt        <= wr_cnt + 1;
                last_wr_addr  <= wr_addr;
            end
            if (snap_req) snap_cnt <= snap_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [3:0] a, input int n, input logic [23:0] d, output bit ok);
        bit k;
        bus_start;
        send_byte(WR_B, k); ok = k;
        send_byte({4'h0, a}, k); ok &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(d[8*i +: 8], k); ok &= k;
        end
        bus_stop;
    endtask

    // leaves the bus open; caller issues the stop
    task automatic do_read(input logic [3:0] a, input int n, output logic [23:0] r, output bit ok);
        bit k;
        logic [7:0] b;
        r = '0;
        bus_start;
        send_byte(WR_B, k); ok = k;
        send_byte({4'h0, a}, k); ok &= k;
        bus_start;
        send_byte(RD_B, k); ok &= k;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            r[8*i +: 8] = b;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        bit k;
        int w0;
        int s0;
        logic [23:0] rb;
        logic [7:0] b;

        for (int i = 0; i < 16; i++) exp_mem[i] = 8'(i * 17 + 3);
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R10 reset state
        chk(!sda_drive_low, "R10 sda released", sda_drive_low, 0);
        chk(!wr_en, "R10 no write strobe", wr_en, 0);
        chk(!snap_req, "R10 no snapshot", snap_req, 0);

        // vector table: single write then read back
        for (int v = 0; v < NVEC; v++) begin
            w0 = wr_cnt;
            do_write(VEC[v][11:8], 1, {16'h0, VEC[v][7:0]}, ok);
            tick(2);
            chk(ok, "R2 write acks", ok, 1);
            chk(wr_cnt == w0 + 1, "R4 one strobe per byte", wr_cnt - w0, 1);
            chk(last_wr_addr == VEC[v][11:8], "R3 pointer load", last_wr_addr, VEC[v][11:8]);
            exp_mem[VEC[v][11:8]] = VEC[v][7:0];
            s0 = snap_cnt;
            do_read(VEC[v][11:8], 1, rb, ok);
            bus_stop;
            chk(ok, "R2 read acks", ok, 1);
            chk(rb[7:0] == exp_mem[VEC[v][11:8]], "R6 read data", rb[7:0], exp_mem[VEC[v][11:8]]);
            chk(snap_cnt == s0 + 1, "R7 one snapshot per read", snap_cnt - s0, 1);
        end

        // R2 foreign address is ignored
        w0 = wr_cnt;
        bus_start;
        send_byte(8'hA4, k);
        chk(!k, "R2 foreign address nack", k, 0);
        send_byte(8'h03, k);
        send_byte(8'h77, k);
        chk(!k, "R2 bytes after foreign address nack", k, 0);
        bus_stop;
        tick(2);
        chk(wr_cnt == w0, "R2 no strobe for foreign address", wr_cnt - w0, 0);

        // R7 read-direction foreign address does not snapshot
        s0 = snap_cnt;
        bus_start;
        send_byte(8'hA5, k);
        bus_stop;
        chk(snap_cnt == s0, "R7 no snapshot on mismatch", snap_cnt - s0, 0);

        // R5 burst write across the wrap
        do_write(4'hE, 3, 24'h7EC35A, ok);
        chk(ok, "R5 burst write acks", ok, 1);
        exp_mem[14] = 8'h5A; exp_mem[15] = 8'hC3; exp_mem[0] = 8'h7E;
        s0 = snap_cnt;
        do_read(4'hE, 3, rb, ok);
        tick(2);
        chk(!sda_drive_low, "R6 released after nack", sda_drive_low, 0);
        bus_stop;
        chk(rb[7:0] == exp_mem[14], "R6 burst byte 0", rb[7:0], exp_mem[14]);
        chk(rb[15:8] == exp_mem[15], "R5 burst byte 1", rb[15:8], exp_mem[15]);
        chk(rb[23:16] == exp_mem[0], "R5 wrap to 0", rb[23:16], exp_mem[0]);
        chk(snap_cnt == s0 + 1, "R7 one snapshot per burst", snap_cnt - s0, 1);

        // R5 current-address read continues at 0x01
        bus_start;
        send_byte(RD_B, k);
        recv_byte(b, 1'b0);
        bus_stop;
        chk(k, "R2 current read ack", k, 1);
        chk(b == exp_mem[1], "R5 pointer after read burst", b, exp_mem[1]);

        // R8 repeated start inside a write
        bus_start;
        send_byte(WR_B, k);
        send_byte(8'h09, k);
        bus_start;
        send_byte(WR_B, k); ok = k;
        send_byte(8'h02, k); ok &= k;
        send_byte(8'h44, k); ok &= k;
        bus_stop;
        exp_mem[2] = 8'h44;
        chk(ok, "R8 repeated start acks", ok, 1);
        do_read(4'h2, 1, rb, ok);
        bus_stop;
        chk(rb[7:0] == 8'h44, "R8 write after repeated start", rb[7:0], 8'h44);

        // R9 stop in the middle of a data byte
        w0 = wr_cnt;
        bus_start;
        send_byte(WR_B, k);
        send_byte(8'h05, k);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop;
        tick(2);
        chk(wr_cnt == w0, "R9 no strobe on partial byte", wr_cnt - w0, 0);
        chk(!sda_drive_low, "R1 released after stop", sda_drive_low, 0);
        do_read(4'h5, 1, rb, ok);
        bus_stop;
        chk(ok, "R1 new start accepted", ok, 1);
        chk(rb[7:0] == exp_mem[5], "R9 register unchanged", rb[7:0], exp_mem[5]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule